// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is the storage stage of one logic macrocell. A data bit is formed from the product-term sum delivered by the allocator. That sum is XORed with a single dedicated term, and a polarity bit can invert the result. A bypass can take the data bit from the pin side instead, so the cell can act as an input register. The data bit then enters a storage element that is configured as an edge-triggered D register, an edge-triggered toggle register or a level-sensitive latch. A fourth mode bypasses storage so that the cell delivers the data bit combinationally.

Several sources can act as the storage clock: four block clocks, an individual term clock (true or inverted), a shared term clock, or a grounded input. The enable also has several sources: an individual term (true or inverted), the shared term clock, or a constant one. The block runs from a single system clock. Each clock source is treated as a level that is sampled every system cycle, and the storage element reacts to a rising edge of the selected source. A block-wide initialization term and two per-cell terms force the state asynchronously. A swap option exchanges which forcing inputs set and which reset, and the same option fixes the value the cell takes at power-up.

Top module: `mc_register`

## Requirements
- R1: While `rst_n` is low the state is `cfg_swap`. When reset is released with no forcing input active, `reg_q` reads 1 if `cfg_swap`=1 and 0 otherwise.
- R2: The data bit is `pin_in` when `cfg_use_pin`=1, else `sum_in ^ single_pt ^ cfg_xor_inv`. With `cfg_mode`=3 (combinational), `mc_out` equals the data bit in the same cycle.
- R3: With `cfg_mode`=0 (D), the state loads the data bit at the system clock edge where the selected source is sampled 1 after being sampled 0 in the previous cycle, provided the enable is 1. Otherwise the state holds.
- R4: `cfg_clk_sel` picks the source: codes 0..3 are `blk_clk[0..3]`, 4 is `pt_clk`, 5 is `pt_clk` inverted, 6 is `shr_clk`, and 7 is ground, which never produces an edge.
- R5: `cfg_ce_sel` picks the enable: 0 is `pt_ice`, 1 is `pt_ice` inverted, 2 is `shr_clk`, and 3 is constant 1.
- R6: With `cfg_mode`=1 (T), an enabled edge inverts the state when the data bit is 1 and keeps it when the data bit is 0.
- R7: With `cfg_mode`=2 (latch), `reg_q` follows the data bit combinationally while the selected source is 1. The value is held while the source is 0, and the enable has no effect.
- R8: With `cfg_swap`=0, `blk_init` or `loc_rst` force `reg_q` to 0 at once, and `loc_set` forces it to 1. With `cfg_swap`=1, `blk_init` or `loc_rst` force 1, and `loc_set` forces 0.
- R9: When a reset request and a set request are both active, `reg_q` is 0.
- R10: After a force held across a system clock edge is removed, the state keeps the forced value.
- R11: In modes 0, 1 and 2, `mc_out` equals `reg_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| blk_clk | input | N_BLK_CLK | Block clock levels |
| pt_clk | input | 1 | Individual term clock level |
| shr_clk | input | 1 | Shared term clock level |
| pt_ice | input | 1 | Individual initialization/enable term |
| blk_init | input | 1 | Block-level initialization term |
| loc_set | input | 1 | Per-cell set term |
| loc_rst | input | 1 | Per-cell reset term |
| sum_in | input | 1 | Allocator sum-of-products |
| single_pt | input | 1 | Single term for the XOR |
| pin_in | input | 1 | Direct input from the pin side |
| cfg_clk_sel | input | CSEL_W | Clock source code |
| cfg_ce_sel | input | 2 | Enable source code |
| cfg_mode | input | 2 | 0 D, 1 T, 2 latch, 3 combinational |
| cfg_xor_inv | input | 1 | Invert the XOR result |
| cfg_use_pin | input | 1 | Take data from `pin_in` |
| cfg_swap | input | 1 | Exchange set and reset roles and the power-up value |
| reg_q | output | 1 | Storage output after forcing |
| mc_out | output | 1 | Cell output: storage or combinational |

## Verification
The hardest case to reach from the ports is a clock edge that comes from a change of selection, not from a change of source level. For example, switching the selection to the inverted individual clock while that clock is low makes the selected level jump from 0 to 1. The bench walks every clock code in turn and keeps each source low while the code changes. A reference model tracks the previously sampled selected level, so it expects such selection edges exactly where they occur. Each code then receives a pulse on every source, which shows that only the chosen source, or none for ground, moves the state.

// File: rtl/mc_reg_pkg.sv
package mc_reg_pkg;

  typedef enum logic [1:0] {
    MODE_D     = 2'd0,
    MODE_T     = 2'd1,
    MODE_LATCH = 2'd2,
    MODE_COMB  = 2'd3
  } mc_mode_e;

  typedef enum logic [1:0] {
    CE_TERM     = 2'd0,
    CE_TERM_INV = 2'd1,
    CE_SHARED   = 2'd2,
    CE_ONE      = 2'd3
  } mc_ce_e;

  // data bit ahead of the storage element
  function automatic logic mc_data(input logic use_pin, input logic pin,
                                   input logic sum, input logic single,
                                   input logic inv);
    logic r;
    r = use_pin ? pin : (sum ^ single ^ inv);
    return r;
  endfunction

  // storage update when no force is active
  function automatic logic mc_next(input mc_mode_e mode, input logic cur,
                                   input logic d, input logic rise,
                                   input logic ce, input logic gate);
    logic r;
    r = cur;
    case (mode)
      MODE_D:     if (rise && ce) r = d;
      MODE_T:     if (rise && ce) r = cur ^ d;
      MODE_LATCH: if (gate) r = d;
      default:    r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel #(
  parameter int N_BLK_CLK = 4,
  localparam int N_SRC  = N_BLK_CLK + 4,
  localparam int CSEL_W = $clog2(N_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_BLK_CLK-1:0] blk_clk,
  input  logic                 pt_clk,
  input  logic                 shr_clk,
  input  logic [CSEL_W-1:0]    sel,
  output logic                 src_lvl,
  output logic                 src_rise
);
  localparam int N_PAD = 2 ** CSEL_W;

  logic [N_PAD-1:0] src_pad;
  logic             lvl_prev;

  generate
    for (genvar i = 0; i < N_PAD; i++) begin : g_src
      if (i < N_BLK_CLK) begin : g_blk
        assign src_pad[i] = blk_clk[i];
      end else if (i == N_BLK_CLK) begin : g_pt
        assign src_pad[i] = pt_clk;
      end else if (i == N_BLK_CLK + 1) begin : g_pt_inv
        assign src_pad[i] = ~pt_clk;
      end else if (i == N_BLK_CLK + 2) begin : g_shr
        assign src_pad[i] = shr_clk;
      end else begin : g_gnd
        assign src_pad[i] = 1'b0;
      end
    end
  endgenerate

  assign src_lvl = src_pad[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= src_lvl;
  end

  assign src_rise = src_lvl & ~lvl_prev;
endmodule

// File: rtl/mc_ce_sel.sv
module mc_ce_sel
  import mc_reg_pkg::*;
(
  input  logic       pt_ice,
  input  logic       shr_clk,
  input  logic [1:0] sel,
  output logic       ce
);
  always_comb begin
    case (mc_ce_e'(sel))
      CE_TERM:     ce = pt_ice;
      CE_TERM_INV: ce = ~pt_ice;
      CE_SHARED:   ce = shr_clk;
      default:     ce = 1'b1;
    endcase
  end
endmodule

// File: rtl/mc_init_ctl.sv
module mc_init_ctl (
  input  logic blk_init,
  input  logic loc_set,
  input  logic loc_rst,
  input  logic swap,
  output logic rst_req,
  output logic set_req,
  output logic pwr_val
);
  logic clear_side;

  assign clear_side = blk_init | loc_rst;
  assign rst_req    = swap ? loc_set    : clear_side;
  assign set_req    = swap ? clear_side : loc_set;
  // block init acting as set means the cell wakes up set
  assign pwr_val    = swap;
endmodule

// File: rtl/mc_register.sv
module mc_register
  import mc_reg_pkg::*;
#(
  parameter int N_BLK_CLK = 4,
  localparam int CSEL_W = $clog2(N_BLK_CLK + 4)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_BLK_CLK-1:0] blk_clk,
  input  logic                 pt_clk,
  input  logic                 shr_clk,
  input  logic                 pt_ice,
  input  logic                 blk_init,
  input  logic                 loc_set,
  input  logic                 loc_rst,
  input  logic                 sum_in,
  input  logic                 single_pt,
  input  logic                 pin_in,
  input  logic [CSEL_W-1:0]    cfg_clk_sel,
  input  logic [1:0]           cfg_ce_sel,
  input  logic [1:0]           cfg_mode,
  input  logic                 cfg_xor_inv,
  input  logic                 cfg_use_pin,
  input  logic                 cfg_swap,
  output logic                 reg_q,
  output logic                 mc_out
);
  mc_mode_e mode;
  logic     d_val;
  logic     src_lvl;
  logic     src_rise;
  logic     ce;
  logic     rst_req;
  logic     set_req;
  logic     pwr_val;
  logic     st_q;
  logic     st_d;

  assign mode  = mc_mode_e'(cfg_mode);
  assign d_val = mc_data(cfg_use_pin, pin_in, sum_in, single_pt, cfg_xor_inv);

  mc_clk_sel #(.N_BLK_CLK(N_BLK_CLK)) i_clk_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .blk_clk  (blk_clk),
    .pt_clk   (pt_clk),
    .shr_clk  (shr_clk),
    .sel      (cfg_clk_sel),
    .src_lvl  (src_lvl),
    .src_rise (src_rise)
  );

  mc_ce_sel i_ce_sel (
    .pt_ice  (pt_ice),
    .shr_clk (shr_clk),
    .sel     (cfg_ce_sel),
    .ce      (ce)
  );

  mc_init_ctl i_init (
    .blk_init (blk_init),
    .loc_set  (loc_set),
    .loc_rst  (loc_rst),
    .swap     (cfg_swap),
    .rst_req  (rst_req),
    .set_req  (set_req),
    .pwr_val  (pwr_val)
  );

  always_comb begin
    if (rst_req)      st_d = 1'b0;
    else if (set_req) st_d = 1'b1;
    else              st_d = mc_next(mode, st_q, d_val, src_rise, ce, src_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= pwr_val;
    else        st_q <= st_d;
  end

  // forces and the open latch act without waiting for a clock
  always_comb begin
    if (rst_req)                          reg_q = 1'b0;
    else if (set_req)                     reg_q = 1'b1;
    else if (mode == MODE_LATCH && src_lvl) reg_q = d_val;
    else                                  reg_q = st_q;
  end

  assign mc_out = (mode == MODE_COMB) ? d_val : reg_q;
endmodule

// File: rtl/mc_register_chk.sv
module mc_register_chk #(
  parameter int N_BLK_CLK = 4,
  localparam int CSEL_W = $clog2(N_BLK_CLK + 4)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic [CSEL_W-1:0] clk_sel,
  input logic              lvl,
  input logic              rise,
  input logic              ce,
  input logic              rst_req,
  input logic              set_req,
  input logic              d_val,
  input logic              state,
  input logic              reg_q,
  input logic              mc_out
);
  localparam logic [CSEL_W-1:0] GND_SEL = CSEL_W'(N_BLK_CLK + 3);

  p_reset_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !reg_q);

  p_set_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !rst_req) |-> reg_q);

  p_comb_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (mc_out == d_val));

  p_out_mirror_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd3) |-> (mc_out == reg_q));

  p_d_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && rise && ce && !rst_req && !set_req) |=> (state == $past(d_val)));

  p_d_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !(rise && ce) && !rst_req && !set_req) |=> $stable(state));

  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && rise && ce && d_val && !rst_req && !set_req) |=> (state != $past(state)));

  p_ground_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == GND_SEL) |-> !rise);

  p_latch_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && lvl && !rst_req && !set_req) |-> (reg_q == d_val));
endmodule

bind mc_register mc_register_chk #(.N_BLK_CLK(N_BLK_CLK)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mode    (cfg_mode),
  .clk_sel (cfg_clk_sel),
  .lvl     (src_lvl),
  .rise    (src_rise),
  .ce      (ce),
  .rst_req (rst_req),
  .set_req (set_req),
  .d_val   (d_val),
  .state   (st_q),
  .reg_q   (reg_q),
  .mc_out  (mc_out)
);

// File: tb/test_mc_register.sv
module test_mc_register;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] blk_clk = '0;
  logic       pt_clk = 1'b0, shr_clk = 1'b0, pt_ice = 1'b0;
  logic       blk_init = 1'b0, loc_set = 1'b0, loc_rst = 1'b0;
  logic       sum_in = 1'b0, single_pt = 1'b0, pin_in = 1'b0;
  logic [2:0] cfg_clk_sel = '0;
  logic [1:0] cfg_ce_sel = 2'd3, cfg_mode = 2'd0;
  logic       cfg_xor_inv = 1'b0, cfg_use_pin = 1'b0, cfg_swap = 1'b0;
  logic       reg_q, mc_out;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;
  logic m_st, m_prev;

  always #10 clk = ~clk;

  mc_register i_mc_register (
    .clk(clk), .rst_n(rst_n), .blk_clk(blk_clk), .pt_clk(pt_clk),
    .shr_clk(shr_clk), .pt_ice(pt_ice), .blk_init(blk_init),
    .loc_set(loc_set), .loc_rst(loc_rst), .sum_in(sum_in),
    .single_pt(single_pt), .pin_in(pin_in), .cfg_clk_sel(cfg_clk_sel),
    .cfg_ce_sel(cfg_ce_sel), .cfg_mode(cfg_mode), .cfg_xor_inv(cfg_xor_inv),
    .cfg_use_pin(cfg_use_pin), .cfg_swap(cfg_swap), .reg_q(reg_q),
    .mc_out(mc_out)
  );

  // reference view of the requirements
  function automatic logic t_data();
    if (cfg_use_pin) return pin_in;
    return (sum_in + single_pt + cfg_xor_inv) % 2 == 1;
  endfunction

  function automatic logic t_lvl();
    case (cfg_clk_sel)
      3'd4:    return pt_clk;
      3'd5:    return !pt_clk;
      3'd6:    return shr_clk;
      3'd7:    return 1'b0;
      default: return blk_clk[cfg_clk_sel[1:0]];
    endcase
  endfunction

  function automatic logic t_ce();
    case (cfg_ce_sel)
      2'd0:    return pt_ice;
      2'd1:    return !pt_ice;
      2'd2:    return shr_clk;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic t_clr();
    return cfg_swap ? loc_set : (blk_init || loc_rst);
  endfunction

  function automatic logic t_set();
    return cfg_swap ? (blk_init || loc_rst) : loc_set;
  endfunction

  task automatic step(input string tag);
    logic er, eo, lv, rs;
    #2;
    if (t_clr())                          er = 1'b0;
    else if (t_set())                     er = 1'b1;
    else if (cfg_mode == 2'd2 && t_lvl()) er = t_data();
    else                                  er = m_st;
    eo = (cfg_mode == 2'd3) ? t_data() : er;
    n_tests++;
    if (reg_q !== er || mc_out !== eo) begin
      n_fail++;
      $display("FAIL %s: reg_q=%0b mc_out=%0b expected reg_q=%0b mc_out=%0b",
               tag, reg_q, mc_out, er, eo);
    end
    @(posedge clk);
    lv = t_lvl();
    rs = lv && !m_prev;
    if (t_clr())      m_st = 1'b0;
    else if (t_set()) m_st = 1'b1;
    else begin
      case (cfg_mode)
        2'd0: if (rs && t_ce()) m_st = t_data();
        2'd1: if (rs && t_ce() && t_data()) m_st = !m_st;
        2'd2: if (lv) m_st = t_data();
        default: ;
      endcase
    end
    m_prev = lv;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic swap);
    rst_n = 1'b0;
    cfg_swap = swap;
    blk_clk = '0; pt_clk = 0; shr_clk = 0;
    blk_init = 0; loc_set = 0; loc_rst = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_st = swap;
    m_prev = 1'b0;
  endtask

  task automatic pulse_src(input int s);
    case (s)
      0, 1, 2, 3: blk_clk[s] = 1'b1;
      4:          pt_clk = 1'b1;
      default:    shr_clk = 1'b1;
    endcase
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: power-up value follows the swap setting
    do_reset(1'b1);
    step("R1 swap=1");
    do_reset(1'b0);
    step("R1 swap=0");

    // R3 R4 R11: every clock code against a pulse on every source
    cfg_mode = 2'd0; cfg_ce_sel = 2'd3;
    for (int sel = 0; sel < 8; sel++) begin
      cfg_clk_sel = 3'(sel);
      step("R4 select change");
      for (int s = 0; s < 6; s++) begin
        sum_in = !sum_in;
        pulse_src(s);
        step("R3 R4 R11 rise");
        blk_clk = '0; pt_clk = 0; shr_clk = 0;
        step("R3 R4 fall");
      end
    end

    // R5: enable sources, clock from blk_clk[0]
    cfg_clk_sel = 3'd0;
    for (int cs = 0; cs < 4; cs++) begin
      for (int v = 0; v < 4; v++) begin
        cfg_ce_sel = 2'(cs);
        pt_ice = v[0]; shr_clk = v[1];
        sum_in = !sum_in;
        step("R5 setup");
        blk_clk[0] = 1'b1;
        step("R5 edge");
        blk_clk[0] = 1'b0;
        step("R5 after");
      end
    end
    pt_ice = 0; shr_clk = 0;

    // R6: toggle mode
    cfg_mode = 2'd1; cfg_ce_sel = 2'd3; cfg_clk_sel = 3'd1;
    for (int i = 0; i < 8; i++) begin
      sum_in = (i % 3) != 0;
      blk_clk[1] = 1'b1;
      step("R6 edge");
      blk_clk[1] = 1'b0;
      step("R6 low");
    end

    // R7: latch gated by the shared clock, enable low and ignored
    cfg_mode = 2'd2; cfg_clk_sel = 3'd6; cfg_ce_sel = 2'd0; pt_ice = 0;
    shr_clk = 1'b1;
    for (int i = 0; i < 4; i++) begin sum_in = !sum_in; step("R7 open"); end
    shr_clk = 1'b0;
    for (int i = 0; i < 4; i++) begin sum_in = !sum_in; step("R7 closed"); end

    // R2: combinational path over all data inputs
    cfg_mode = 2'd3;
    for (int v = 0; v < 32; v++) begin
      {cfg_use_pin, pin_in, sum_in, single_pt, cfg_xor_inv} = 5'(v);
      step("R2 comb");
    end
    cfg_use_pin = 0; cfg_xor_inv = 0;

    // R8 R9 R10: forcing with and without swap, clock grounded
    cfg_mode = 2'd0; cfg_clk_sel = 3'd7; cfg_ce_sel = 2'd3;
    for (int v = 0; v < 16; v++) begin
      {cfg_swap, blk_init, loc_set, loc_rst} = 4'(v);
      sum_in = !sum_in;
      step("R8 R9 force");
      blk_init = 0; loc_set = 0; loc_rst = 0;
      step("R10 hold");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule